// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Product Seeding

This block forms the product of two 18-bit operands and folds it into a 44-bit two's-complement accumulator. Each valid beat is either a seed beat or a combine beat. A seed beat overwrites the accumulator with the fresh product. A combine beat merges the product with the stored total. The merge is an addition or a subtraction, and that choice is made once, by a parameter, when the block is elaborated. A run-time sign input tells the multiplier whether to treat the operands as two's-complement or as unsigned numbers.

Saturation and rounding are optional and are each selected by a parameter. When saturation is on, a combine beat that would leave the 44-bit range is clamped to the nearest extreme, and a flag is raised. When rounding is on, the accumulator is rounded half-up at a chosen bit position before it reaches the output. Input and output pipeline registers can each be switched in to shorten the timing paths, at a cost of one cycle of latency each.

Filter taps and dot products are the typical uses. Seed on the first term of a sum, then combine on every later term, and no separate clear cycle is needed between sums.

Top module: `mac_acc`

## Requirements
- R1: With `sgn_i`=1 the operands are two's-complement and the 36-bit product is sign-extended to 44 bits. With `sgn_i`=0 the operands are unsigned and the product is zero-extended.
- R2: A valid beat with `load_i`=1 replaces the accumulator with the product of that beat, and the previous total is discarded.
- R3: A valid beat with `load_i`=0 sets the accumulator to accumulator + product when `SUBTRACT`=0, and to accumulator − product when `SUBTRACT`=1.
- R4: While `vld_i` is 0, the accumulator keeps its value whatever the other inputs do, and `ovf_o` raises no new overflow pulse.
- R5: With `SAT_EN`=1, a combine beat that overflows clamps the accumulator to 0x7FF_FFFF_FFFF (positive overflow) or to 0x800_0000_0000 (negative overflow), and `ovf_o` is 1 for exactly the one output cycle that belongs to that beat.
- R6: With `SAT_EN`=0, the accumulator wraps modulo 2^44, and `ovf_o` still pulses for the overflowing beat.
- R7: With `ROUND_EN`=1, `res_o` is the accumulator plus 2^(`ROUND_POS`−1), with bits `ROUND_POS`−1..0 cleared. An exact half therefore rounds toward positive infinity.
- R8: With `ROUND_EN`=1 and `SAT_EN`=1, a rounding step that would exceed the positive limit gives the largest positive value with the low `ROUND_POS` bits cleared. `ovf_o` stays 1 for as long as that clamped output is shown.
- R9: A valid beat driven at a clock edge appears on `res_o` after 1 + `IN_REG` + `OUT_REG` rising edges. That is 3 edges with the default parameters, and `res_o` is unchanged after 2.
- R10: A synchronous `rst` clears the accumulator and every pipeline register, so `res_o`=0 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Beat valid strobe |
| sgn_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| load_i | input | 1 | 1 = seed with product, 0 = combine with accumulator |
| a_i | input | OP_W (18) | First operand |
| b_i | input | OP_W (18) | Second operand |
| res_o | output | ACC_W (44) | Accumulated, optionally rounded, result |
| ovf_o | output | 1 | Overflow or clamp indication |

## Verification
The bench builds two copies of the block side by side, both with input and output registers, so they share the three-edge timing. The first copy uses the default parameters: addition, saturation, and rounding at bit 8. That copy reaches both saturation clamps, the rounding clamp, and the half-up ties. The second copy subtracts, with rounding and saturation both off. It exposes the raw accumulator, so the subtract direction and the modular wrap can be observed directly.

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int OP_W      = 18,
  parameter int ACC_W     = 44,
  parameter int SUBTRACT  = 0,
  parameter int IN_REG    = 1,
  parameter int OUT_REG   = 1,
  parameter int ROUND_EN  = 1,
  parameter int ROUND_POS = 8,
  parameter int SAT_EN    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             sgn_i,
  input  logic             load_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] res_o,
  output logic             ovf_o
);
  localparam int PW = 2 * OP_W;
  localparam int XW = ACC_W - PW;
  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic            s_vld, s_sgn, s_ld;
  logic [OP_W-1:0] s_a, s_b;

  generate
    if (IN_REG != 0) begin : g_in_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          s_vld <= 1'b0;
          s_sgn <= 1'b0;
          s_ld  <= 1'b0;
          s_a   <= '0;
          s_b   <= '0;
        end else begin
          s_vld <= vld_i;
          s_sgn <= sgn_i;
          s_ld  <= load_i;
          s_a   <= a_i;
          s_b   <= b_i;
        end
      end
    end else begin : g_in_pass
      assign s_vld = vld_i;
      assign s_sgn = sgn_i;
      assign s_ld  = load_i;
      assign s_a   = a_i;
      assign s_b   = b_i;
    end
  endgenerate

  logic signed [PW-1:0] prod_s;
  logic        [PW-1:0] prod_u;
  logic     [ACC_W-1:0] prod_x;

  assign prod_s = $signed(s_a) * $signed(s_b);
  assign prod_u = s_a * s_b;
  assign prod_x = s_sgn ? {{XW{prod_s[PW-1]}}, prod_s} : {{XW{1'b0}}, prod_u};

  logic [ACC_W-1:0] acc, acc_nxt;
  logic             acc_ovf;
  logic [ACC_W:0]   comb;
  logic             comb_ovf;

  assign comb = (SUBTRACT != 0) ? ({acc[ACC_W-1], acc} - {prod_x[ACC_W-1], prod_x})
                                : ({acc[ACC_W-1], acc} + {prod_x[ACC_W-1], prod_x});
  assign comb_ovf = comb[ACC_W] ^ comb[ACC_W-1];
  assign acc_nxt  = s_ld ? prod_x
                  : (comb_ovf && SAT_EN != 0) ? (comb[ACC_W] ? MINV : MAXV)
                  : comb[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      acc_ovf <= 1'b0;
    end else begin
      acc_ovf <= s_vld & ~s_ld & comb_ovf;
      if (s_vld) acc <= acc_nxt;
    end
  end

  logic [ACC_W-1:0] rnd;
  logic             rnd_ovf;

  generate
    if (ROUND_EN != 0) begin : g_round
      localparam logic [ACC_W:0]   HALF = (ACC_W+1)'(1) << (ROUND_POS - 1);
      localparam logic [ACC_W-1:0] MAXR = {1'b0, {(ACC_W-1-ROUND_POS){1'b1}}, {ROUND_POS{1'b0}}};
      logic [ACC_W:0] rsum;
      assign rsum    = {acc[ACC_W-1], acc} + HALF;
      assign rnd_ovf = rsum[ACC_W] ^ rsum[ACC_W-1];
      assign rnd     = (rnd_ovf && SAT_EN != 0) ? MAXR
                     : {rsum[ACC_W-1:ROUND_POS], {ROUND_POS{1'b0}}};
    end else begin : g_no_round
      assign rnd     = acc;
      assign rnd_ovf = 1'b0;
    end
  endgenerate

  generate
    if (OUT_REG != 0) begin : g_out_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_o <= '0;
          ovf_o <= 1'b0;
        end else begin
          res_o <= rnd;
          ovf_o <= acc_ovf | rnd_ovf;
        end
      end
    end else begin : g_out_pass
      assign res_o = rnd;
      assign ovf_o = acc_ovf | rnd_ovf;
    end
  endgenerate

  p_seed_r2: assert property (@(posedge clk) disable iff (rst)
    s_vld && s_ld |=> acc == $past(prod_x));

  p_combine_r3: assert property (@(posedge clk) disable iff (rst)
    s_vld && !s_ld && !comb_ovf |=>
      acc == ((SUBTRACT != 0) ? ($past(acc) - $past(prod_x)) : ($past(acc) + $past(prod_x))));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !s_vld |=> acc == $past(acc) && !acc_ovf);

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> acc == '0 && !acc_ovf);

  generate
    if (SAT_EN != 0) begin : g_sat_chk
      p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        acc_ovf |-> (acc == MAXV || acc == MINV));
    end
    if (ROUND_EN != 0) begin : g_rnd_chk
      p_low_clear_r7: assert property (@(posedge clk) disable iff (rst)
        res_o[ROUND_POS-1:0] == '0);
    end
  endgenerate
endmodule

// File: tb/mac_acc_bench.sv
`timescale 1ns/1ps
module mac_acc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0, sgn = 1'b0, ld = 1'b0;
  logic [17:0] a = '0, b = '0;
  logic [43:0] res1, res2;
  logic        ovf1, ovf2;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_acc u_mac_acc (
    .clk(clk), .rst(rst), .vld_i(vld), .sgn_i(sgn), .load_i(ld),
    .a_i(a), .b_i(b), .res_o(res1), .ovf_o(ovf1));

  mac_acc #(.SUBTRACT(1), .ROUND_EN(0), .SAT_EN(0)) u_mac_acc_wrap (
    .clk(clk), .rst(rst), .vld_i(vld), .sgn_i(sgn), .load_i(ld),
    .a_i(a), .b_i(b), .res_o(res2), .ovf_o(ovf2));

  localparam logic [43:0] MAXV = 44'h7FF_FFFF_FFFF;
  localparam logic [43:0] MINV = 44'h800_0000_0000;
  localparam logic [43:0] MAXR = 44'h7FF_FFFF_FF00;

  // {a, b, sgn, load}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {18'd3,      18'd5,      1'b0, 1'b1},
    {18'd1000,   18'd1000,   1'b0, 1'b0},
    {18'h3FFF9,  18'd300,    1'b1, 1'b0},
    {18'h3FFFF,  18'h3FFFF,  1'b1, 1'b0},
    {18'h3FFFF,  18'h3FFFF,  1'b0, 1'b0},
    {18'h20000,  18'd5,      1'b1, 1'b1},
    {18'h1FFFF,  18'h1FFFF,  1'b1, 1'b0},
    {18'd12345,  18'd54321,  1'b0, 1'b0},
    {18'd0,      18'h2AAAA,  1'b0, 1'b1},
    {18'h20000,  18'h20000,  1'b1, 1'b0},
    {18'h3FFFF,  18'd2,      1'b0, 1'b1},
    {18'h3FFFF,  18'd2,      1'b1, 1'b1}
  };

  logic [43:0] m1 = '0, m2 = '0, e1 = '0, e2 = '0;
  logic        eo1 = 1'b0, eo2 = 1'b0;

  task automatic check(input bit ok, input string req, input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [43:0] pext(input logic [17:0] x, input logic [17:0] y, input logic s);
    logic signed [35:0] ps;
    logic [35:0] pu;
    ps = $signed(x) * $signed(y);
    pu = x * y;
    return s ? {{8{ps[35]}}, ps} : {8'b0, pu};
  endfunction

  task automatic model(input logic [17:0] x, input logic [17:0] y, input logic s, input logic l);
    logic [43:0] p;
    logic [44:0] t, r;
    logic ov, rov;
    p = pext(x, y, s);
    t = {m1[43], m1} + {p[43], p};
    ov = t[44] ^ t[43];
    m1 = l ? p : (ov ? (t[44] ? MINV : MAXV) : t[43:0]);
    eo1 = !l && ov;
    t = {m2[43], m2} - {p[43], p};
    eo2 = !l && (t[44] ^ t[43]);
    m2 = l ? p : t[43:0];
    r = {m1[43], m1} + 45'd128;
    rov = r[44] ^ r[43];
    e1 = rov ? MAXR : {r[43:8], 8'h00};
    eo1 = eo1 | rov;
    e2 = m2;
  endtask

  task automatic op(input logic [17:0] x, input logic [17:0] y, input logic s, input logic l, input string req);
    logic [43:0] prev1;
    prev1 = e1;
    @(negedge clk);
    a = x; b = y; sgn = s; ld = l; vld = 1'b1;
    model(x, y, s, l);
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    check(res1 === prev1, "R9 early", res1, prev1);
    @(negedge clk);
    check(res1 === e1, req, res1, e1);
    check(ovf1 === eo1, req, {43'b0, ovf1}, {43'b0, eo1});
    check(res2 === e2, req, res2, e2);
    check(ovf2 === eo2, req, {43'b0, ovf2}, {43'b0, eo2});
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res1 === 44'd0 && ovf1 === 1'b0, "R10 reset", res1, 44'd0);
    check(res2 === 44'd0 && ovf2 === 1'b0, "R10 reset", res2, 44'd0);
    rst = 1'b0;

    // vector table: R1 R2 R3 R6 R7 R9 via model
    for (int i = 0; i < NV; i++)
      op(VEC[i][37:20], VEC[i][19:2], VEC[i][1], VEC[i][0], "R1/R2/R3 vector");

    // R1 hand values: 0x3FFFF*2 unsigned vs signed (wrap copy shows raw value)
    op(18'h3FFFF, 18'd2, 1'b0, 1'b1, "R1 unsigned");
    check(res2 === 44'h0000007FFFE, "R1 unsigned", res2, 44'h0000007FFFE);
    op(18'h3FFFF, 18'd2, 1'b1, 1'b1, "R1 signed");
    check(res2 === 44'hFFFFFFFFFFE, "R1 signed", res2, 44'hFFFFFFFFFFE);

    // R2 seed discards old total, R3 subtract direction on wrap copy
    op(18'd10, 18'd10, 1'b0, 1'b1, "R2 seed");
    check(res2 === 44'd100, "R2 seed", res2, 44'd100);
    op(18'd3, 18'd4, 1'b0, 1'b0, "R3 combine");
    check(res2 === 44'd88, "R3 subtract", res2, 44'd88);

    // R4: inputs change without valid
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      a = 18'(k * 777 + 5); b = 18'h2F0F0; ld = k[0]; sgn = k[1];
    end
    @(negedge clk);
    check(res1 === e1 && ovf1 === 1'b0, "R4 hold", res1, e1);
    check(res2 === e2 && ovf2 === 1'b0, "R4 hold", res2, e2);

    // R7 ties and rounding direction
    op(18'd16, 18'd8, 1'b0, 1'b1, "R7");
    check(res1 === 44'd256, "R7 half up", res1, 44'd256);
    op(18'd127, 18'd1, 1'b0, 1'b1, "R7");
    check(res1 === 44'd0, "R7 below half", res1, 44'd0);
    op(18'h3FFFF, 18'd128, 1'b1, 1'b1, "R7");
    check(res1 === 44'd0, "R7 negative half", res1, 44'd0);
    op(18'h3FFFF, 18'd129, 1'b1, 1'b1, "R7");
    check(res1 === 44'hFFFFFFFFF00, "R7 negative", res1, 44'hFFFFFFFFF00);

    // R5 positive clamp, R8 rounding clamp, R6 wrap
    op(18'h20000, 18'h20000, 1'b1, 1'b1, "R5 seed");
    for (int k = 0; k < 520; k++)
      op(18'h20000, 18'h20000, 1'b1, 1'b0, "R5/R6 climb");
    check(res1 === MAXR && ovf1 === 1'b1, "R8 round clamp", res1, MAXR);
    check(res2 === 44'h7E400000000, "R6 wrap", res2, 44'h7E400000000);

    // R5 negative clamp
    op(18'h20000, 18'h1FFFF, 1'b1, 1'b1, "R5 seed");
    for (int k = 0; k < 520; k++)
      op(18'h20000, 18'h1FFFF, 1'b1, 1'b0, "R5/R6 descend");
    check(res1 === MINV && ovf1 === 1'b1, "R5 negative clamp", res1, MINV);

    // R5 pulse is one cycle: hold a cycle without valid after a non-rounding overflow
    @(negedge clk);
    check(ovf1 === 1'b0, "R5 single pulse", {43'b0, ovf1}, 44'd0);

    // R10 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m1 = '0; m2 = '0; e1 = '0; e2 = '0;
    check(res1 === 44'd0 && ovf1 === 1'b0, "R10 mid reset", res1, 44'd0);
    check(res2 === 44'd0 && ovf2 === 1'b0, "R10 mid reset", res2, 44'd0);
    op(18'd7, 18'd9, 1'b0, 1'b0, "R10 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule